// File: doc/BRIEF.md
# Almost-Flag Offset Programmer

This block keeps the two threshold offsets of a FIFO, one that marks the nearly-empty state (X) and one that marks the nearly-full state (Y). From them it produces the two active-low threshold flags. The FIFO core supplies two counts, the number of words stored and the number of free slots. The block compares each count against its offset every cycle. The block does not hold any data storage and does not move counts between clock domains.

The offsets can be programmed in three ways. The choice is made by a two-bit select that is sampled while reset is held. The block can load a fixed preset into both offsets. It can take the two offsets from consecutive writes on the write data bus. It can also shift them in one bit at a time on a serial input. In the serial case a single stream of 2·log2(DEPTH) bits fills Y first and then X, with the most significant bit first.

Until programming is complete, ordinary writes to the FIFO are held back. A done output reports when both offsets hold their final values.

Top module: `fifo_offset_prog`

## Requirements
- R1: The select value present at the last clock edge while `rst_n` is low fixes the programming method until the next reset. Changes to `sel` after release have no effect. The codes are 2'b00 serial, 2'b01 preset A (8), 2'b10 preset B (16) and 2'b11 parallel.
- R2: While `rst_n` is low, `prog_done` and `fifo_wr_ok` are low. Both offsets read 0 when the code is serial or parallel.
- R3: With a preset code, X and Y both equal the preset (8 for 2'b01, 16 for 2'b10), and `prog_done` is high from the first cycle after reset release.
- R4: In serial mode, each clock edge with `ser_en_n` low shifts `ser_din` into the concatenation {Y,X} at the X LSB end, so the first bit ends in the Y MSB. Edges with `ser_en_n` high shift nothing. After OW bits (OW = log2(DEPTH)), X holds the first OW bits and Y is still 0.
- R5: `prog_done` rises on the edge that takes serial bit number 2·OW (18 for depth 512). Serial bits after that leave X and Y unchanged.
- R6: In parallel mode, the first write (`wr_en` high) after reset loads Y from `wr_data[OW-1:0]`. The second write loads X from the same bits and raises `prog_done`. Later writes leave X and Y unchanged.
- R7: `fifo_wr_ok` is high exactly when `wr_en` is high and `prog_done` is high. Writes made during programming never pass through.
- R8: `almost_empty_n` is low exactly when `word_count` is less than or equal to X.
- R9: `almost_full_n` is low exactly when `free_count` is less than or equal to Y.
- R10: Inputs that belong to another method are ignored. Serial bits do not change the offsets in parallel or preset mode, and writes do not change them in serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous active-low reset; method is captured while low |
| sel | input | 2 | Programming method select |
| ser_en_n | input | 1 | Active-low serial shift enable |
| ser_din | input | 1 | Serial offset data |
| wr_en | input | 1 | Write request from the write port |
| wr_data | input | DW | Write data bus |
| word_count | input | OW+1 | Words currently stored |
| free_count | input | OW+1 | Empty slots currently available |
| almost_empty_n | output | 1 | Low when word_count <= X |
| almost_full_n | output | 1 | Low when free_count <= Y |
| prog_done | output | 1 | Both offsets programmed |
| fifo_wr_ok | output | 1 | Write request passed on to the FIFO core |
| x_off | output | OW | Current almost-empty offset |
| y_off | output | OW | Current almost-full offset |

## Verification
All four select codes are exercised, and the select is moved both during reset and after release. This separates a latched method from a live one. Random serial patterns with idle gaps are inspected halfway and at the end of the stream. The halfway point tells a Y-first, MSB-first order apart from other bit orders, and the gaps test that disabled edges do not count. Extra bits and extra writes after completion, along with stimulus that belongs to the wrong method, show that the offsets freeze. Random counts mixed with counts exactly at and one above each offset pin down the less-than-or-equal boundary of both flags.

// File: rtl/fifo_offset_prog.sv
module fifo_offset_prog #(
  parameter int DEPTH    = 512,
  parameter int DW       = 36,
  parameter int PRESET_A = 8,
  parameter int PRESET_B = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               sel,
  input  logic                     ser_en_n,
  input  logic                     ser_din,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH):0]   word_count,
  input  logic [$clog2(DEPTH):0]   free_count,
  output logic                     almost_empty_n,
  output logic                     almost_full_n,
  output logic                     prog_done,
  output logic                     fifo_wr_ok,
  output logic [$clog2(DEPTH)-1:0] x_off,
  output logic [$clog2(DEPTH)-1:0] y_off
);
  localparam int OW = $clog2(DEPTH);
  localparam int CW = OW + 1;
  localparam int NB = 2 * OW;
  localparam int KW = $clog2(NB + 1);
  localparam logic [1:0] M_SER = 2'b00, M_PA = 2'b01, M_PB = 2'b10, M_PAR = 2'b11;

  logic [1:0]    mode_q;
  logic [OW-1:0] x_q, y_q;
  logic [KW-1:0] cnt_q;
  logic          done_q;

  function automatic logic [OW-1:0] preset_of(input logic [1:0] s);
    case (s)
      M_PA:    return OW'(PRESET_A);
      M_PB:    return OW'(PRESET_B);
      default: return '0;
    endcase
  endfunction

  wire ser_step = (mode_q == M_SER) && !done_q && !ser_en_n;
  wire par_step = (mode_q == M_PAR) && !done_q && wr_en;
  wire unused_hi = &{1'b0, wr_data[DW-1:OW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= sel;
      cnt_q  <= '0;
      done_q <= (sel == M_PA) || (sel == M_PB);
      x_q    <= preset_of(sel);
      y_q    <= preset_of(sel);
    end else begin
      if (ser_step) begin
        {y_q, x_q} <= {y_q[OW-2:0], x_q, ser_din};
        cnt_q      <= cnt_q + 1'b1;
        if (cnt_q == KW'(NB - 1)) done_q <= 1'b1;
      end
      if (par_step) begin
        if (cnt_q == '0) y_q <= wr_data[OW-1:0];
        else begin
          x_q    <= wr_data[OW-1:0];
          done_q <= 1'b1;
        end
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign x_off          = x_q;
  assign y_off          = y_q;
  assign prog_done      = rst_n & done_q;
  assign fifo_wr_ok     = wr_en & prog_done;
  assign almost_empty_n = word_count > CW'(x_q);
  assign almost_full_n  = free_count > CW'(y_q);

  p_mode_latched_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));
  p_serial_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_step |=> x_off[0] == $past(ser_din));
  p_serial_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_step && cnt_q == KW'(NB - 1)) |=> prog_done);
  p_done_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> prog_done);
  p_par_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (par_step && cnt_q == '0) |=> (y_off == $past(wr_data[OW-1:0])) && !prog_done);
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> $stable(x_off) && $stable(y_off));
endmodule

// File: tb/sim_fifo_offset_prog.sv
module sim_fifo_offset_prog;
  localparam int DEPTH = 512;
  localparam int DW    = 36;
  localparam int OW    = $clog2(DEPTH);
  localparam int CW    = OW + 1;
  localparam int NB    = 2 * OW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic ser_en_n = 1'b1, ser_din = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] word_count = '0, free_count = '0;
  logic ae_n, af_n, done, wr_ok;
  logic [OW-1:0] x_off, y_off;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  fifo_offset_prog #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ser_en_n(ser_en_n), .ser_din(ser_din),
    .wr_en(wr_en), .wr_data(wr_data), .word_count(word_count), .free_count(free_count),
    .almost_empty_n(ae_n), .almost_full_n(af_n), .prog_done(done), .fifo_wr_ok(wr_ok),
    .x_off(x_off), .y_off(y_off));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit exp_flag(input int cnt, input int off);
    return cnt > off;
  endfunction

  task automatic do_reset(input logic [1:0] early, input logic [1:0] last);
    @(negedge clk);
    rst_n = 1'b0; sel = early; wr_en = 1'b1; ser_en_n = 1'b1;
    step(); step();
    sel = last;
    step();
    #1;
    chk(done == 1'b0, "R2 done low in reset", done, 0);
    chk(wr_ok == 1'b0, "R2 wr_ok low in reset", wr_ok, 0);
    step();
    rst_n = 1'b1; wr_en = 1'b0; sel = ~last;
  endtask

  task automatic flag_sweep(input int xo, input int yo);
    for (int k = 0; k < 30; k++) begin
      int wc, fc;
      case (k % 5)
        0: begin wc = xo;     fc = yo;     end
        1: begin wc = xo + 1; fc = yo + 1; end
        2: begin wc = 0;      fc = DEPTH;  end
        default: begin wc = $urandom_range(0, DEPTH); fc = $urandom_range(0, DEPTH); end
      endcase
      word_count = CW'(wc); free_count = CW'(fc);
      #1;
      chk(ae_n == exp_flag(wc, xo), "R8 almost_empty_n", ae_n, exp_flag(wc, xo));
      chk(af_n == exp_flag(fc, yo), "R9 almost_full_n", af_n, exp_flag(fc, yo));
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [OW-1:0] ry, rx, w1, w2;
    logic [NB-1:0] stream;
    void'($urandom(32'd1234));

    // serial mode; select wanders during reset, final code 00
    do_reset(2'b10, 2'b00);
    #1;
    chk(x_off == 0 && y_off == 0, "R2 offsets zero after serial reset", x_off, 0);
    ry = OW'($urandom); rx = OW'($urandom);
    stream = {ry, rx};
    for (int i = 0; i < NB; i++) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        ser_en_n = 1'b1; ser_din = $urandom_range(0, 1); wr_en = 1'b1; wr_data = DW'($urandom);
        #1;
        chk(wr_ok == 1'b0, "R7 write blocked while programming", wr_ok, 0);
        step();
      end
      wr_en = 1'b0; ser_en_n = 1'b0; ser_din = stream[NB-1-i];
      step();
      if (i == OW - 1) begin
        chk(x_off == ry, "R4 first half lands in X position", x_off, ry);
        chk(y_off == 0, "R4 Y empty at half stream", y_off, 0);
      end
      if (i == NB - 2) chk(done == 1'b0, "R5 not done one bit early", done, 0);
    end
    ser_en_n = 1'b1;
    chk(done == 1'b1, "R5 done after full stream", done, 1);
    chk(y_off == ry, "R4 Y value", y_off, ry);
    chk(x_off == rx, "R4 X value", x_off, rx);
    for (int i = 0; i < 3; i++) begin
      ser_en_n = 1'b0; ser_din = ~ser_din;
      step();
    end
    ser_en_n = 1'b1;
    chk(y_off == ry && x_off == rx, "R5 extra bits ignored", x_off, rx);
    wr_en = 1'b1; #1;
    chk(wr_ok == 1'b1, "R7 write passes after done", wr_ok, 1);
    wr_en = 1'b0;
    flag_sweep(rx, ry);

    // preset A, select changed afterwards
    do_reset(2'b11, 2'b01);
    #1;
    chk(done == 1'b1, "R3 preset done at release", done, 1);
    chk(x_off == 8 && y_off == 8, "R3 preset A", x_off, 8);
    step();
    chk(x_off == 8, "R1 mode kept after select change", x_off, 8);
    flag_sweep(8, 8);

    // preset B, serial bits afterwards are ignored
    do_reset(2'b01, 2'b10);
    #1;
    chk(x_off == 16 && y_off == 16, "R3 preset B", y_off, 16);
    sel = 2'b00;
    for (int i = 0; i < 5; i++) begin
      ser_en_n = 1'b0; ser_din = 1'b1;
      step();
    end
    ser_en_n = 1'b1;
    chk(x_off == 16 && y_off == 16, "R10 serial ignored in preset", x_off, 16);
    flag_sweep(16, 16);

    // parallel
    do_reset(2'b00, 2'b11);
    for (int i = 0; i < 5; i++) begin
      ser_en_n = 1'b0; ser_din = 1'b1;
      step();
    end
    ser_en_n = 1'b1;
    chk(x_off == 0 && y_off == 0 && done == 1'b0, "R10 serial ignored in parallel", x_off, 0);
    w1 = OW'($urandom); w2 = OW'($urandom);
    wr_en = 1'b1; wr_data = {DW'($urandom) << OW} | DW'(w1);
    #1;
    chk(wr_ok == 1'b0, "R7 first programming write blocked", wr_ok, 0);
    step();
    chk(y_off == w1, "R6 first write loads Y", y_off, w1);
    chk(done == 1'b0, "R6 not done after one write", done, 0);
    wr_en = 1'b0; step();
    wr_en = 1'b1; wr_data = {DW'($urandom) << OW} | DW'(w2);
    step();
    chk(x_off == w2, "R6 second write loads X", x_off, w2);
    chk(done == 1'b1, "R6 done after second write", done, 1);
    wr_data = DW'(~w2);
    #1;
    chk(wr_ok == 1'b1, "R7 normal write passes", wr_ok, 1);
    step();
    wr_en = 1'b0;
    chk(x_off == w2 && y_off == w1, "R6 later write ignored", x_off, w2);
    flag_sweep(w2, w1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule